// File: doc/BRIEF.md
# Pulse-Skipping Overcurrent Controller

This block sits between the PWM modulator of a step-down converter and the high-side switch driver, and it guards each switching period. A strobe marks the start of every period. On that strobe the block either turns the switch on or skips the whole period. Once the switch is on, the gate follows the modulator's on-request. For a programmable number of clocks after turn-on, the current-limit comparator is ignored, because switching noise would otherwise cause false trips.

On the first clock after that blanking window the comparator is read exactly once. An over-limit reading cuts the gate for the rest of the period. The response to an over-limit reading then depends on the converter phase:
- **Soft-start:** the block raises a skip level, which caps at seven, and drops that many following periods. This holds the delivered current near the limit.
- **Regulation:** the block pulses a hiccup request to the reference sequencer and forgets any skip history.

An under-limit reading lowers the skip level by one. Under a hard short, the sequencer's hiccup off-time alternates with this constant-current mode, in which at most one period in eight is switched.

All pins are plain control signals sampled on the rising clock edge. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `ocp_skip_ctrl`

## Requirements
- R1: While reset is held, `gate_en` and `hiccup_req` are low. After reset the skip level is zero, so the first period strobe turns the switch on.
- R2: A period strobe with no skips pending turns the switch on from the next clock. `gate_en` then equals `pwm_on` until the request falls, a trip occurs, or the next strobe arrives. Once `pwm_on` falls, the gate stays low for the rest of the period.
- R3: For `BLANK_CYC` clock edges after the turn-on edge, `ilim_trip` has no effect on `gate_en`, `hiccup_req` or the skip level.
- R4: On the clock edge after blanking expires, `ilim_trip` is sampled once, provided `pwm_on` is still high. If `ilim_trip` is high at that edge, `gate_en` is low from that edge until the next period strobe.
- R5: With `ss_active` high, an over-limit sample raises the skip level by one, saturating at `SKIP_MAX` (7). The same number of following periods is then skipped, so consecutive trips give 1, 2, 3, and so on up to 7 skipped periods. When `ss_active` and `in_reg` are both high, the soft-start response takes priority.
- R6: In a skipped period, `gate_en` stays low for the whole period, no sample is taken and the skip level is unchanged.
- R7: An under-limit sample lowers the skip level by one, with a floor of zero, and causes no skipped period.
- R8: With `ss_active` low and `in_reg` high, an over-limit sample raises `hiccup_req` for exactly one clock, on the clock after the sampling edge. The same edge clears the skip level and any pending skips.
- R9: If `pwm_on` falls before the sampling edge, the switch turns off with no sample. The skip level is unchanged and the next period is not skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe at the start of each switching period |
| ilim_trip | input | 1 | Current-limit comparator, high when current exceeds the limit |
| pwm_on | input | 1 | Modulator on-request for the switch |
| ss_active | input | 1 | High while the reference is ramping in soft-start |
| in_reg | input | 1 | High once the output is in regulation |
| gate_en | output | 1 | Switch gate enable |
| hiccup_req | output | 1 | One-clock request to the sequencer for a hiccup restart |

## Verification
The bench drives a comparator that is high only during blanking and low at the sampling edge. A design that sampled too early would cut the gate short or request a hiccup here.

A sustained soft-start overload must produce the exact skip pattern 1, 2, … 7, 7. An off-by-one in the counter, a missed saturation or a skip that still opens the gate would each change the per-period gate count.

Two further cases cover the remaining traps:
- **Under-limit decay:** under-limit periods followed by a fresh trip must skip one fewer period than the saturated run. This catches a design that clears the level instead of decrementing it.
- **Short request:** an on-request shorter than the blanking window must leave the skip level untouched.

Finally, a hiccup in regulation must reset the level, so the next soft-start trip skips a single period.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    SW_OFF     = 2'd0,
    SW_BLANK   = 2'd1,
    SW_CONDUCT = 2'd2
  } sw_state_e;
endpackage

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
  parameter int BLANK_CYC = 4,
  parameter int CNT_W     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(BLANK_CYC);
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ocp_skip_tracker.sv
module ocp_skip_tracker #(
  parameter int SKIP_MAX = 7,
  parameter int SKIP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bump,
  input  logic              ease,
  input  logic              take,
  output logic [SKIP_W-1:0] level,
  output logic              pending
);
  logic [SKIP_W-1:0] lvl_q, lvl_d, left_q, left_d;

  always_comb begin
    lvl_d  = lvl_q;
    left_d = left_q;
    if (bump) begin
      lvl_d  = (lvl_q == SKIP_W'(SKIP_MAX)) ? lvl_q : lvl_q + 1'b1;
      left_d = lvl_d;
    end else if (ease && lvl_q != '0) begin
      lvl_d = lvl_q - 1'b1;
    end
    if (take && left_q != '0) begin
      left_d = left_q - 1'b1;
    end
    if (clr) begin
      lvl_d  = '0;
      left_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      left_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      left_q <= left_d;
    end
  end

  assign level   = lvl_q;
  assign pending = (left_q != '0);
endmodule

// File: rtl/ocp_skip_ctrl.sv
module ocp_skip_ctrl
  import ocp_pkg::*;
#(
  parameter int BLANK_CYC = 4,
  parameter int SKIP_MAX  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic ilim_trip,
  input  logic pwm_on,
  input  logic ss_active,
  input  logic in_reg,
  output logic gate_en,
  output logic hiccup_req
);
  localparam int BLK_W  = $clog2(BLANK_CYC + 2);
  localparam int SKIP_W = $clog2(SKIP_MAX + 1);

  sw_state_e         st_q, st_d;
  logic              blank_done, skip_pend;
  logic [SKIP_W-1:0] skip_cnt;
  logic              start_on, take_skip, sample_now;
  logic              over_ev, under_ev, bump_ev, hic_d;

  assign start_on   = cyc_start & ~skip_pend;
  assign take_skip  = cyc_start & skip_pend;
  assign sample_now = ~cyc_start & (st_q == SW_BLANK) & blank_done & pwm_on;
  assign over_ev    = sample_now & ilim_trip;
  assign under_ev   = sample_now & ~ilim_trip;
  assign bump_ev    = over_ev & ss_active;
  assign hic_d      = over_ev & ~ss_active & in_reg;

  ocp_blank_timer #(.BLANK_CYC(BLANK_CYC), .CNT_W(BLK_W)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_on),
    .run     (st_q == SW_BLANK),
    .expired (blank_done)
  );

  ocp_skip_tracker #(.SKIP_MAX(SKIP_MAX), .SKIP_W(SKIP_W)) u_skip (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (hic_d),
    .bump    (bump_ev),
    .ease    (under_ev),
    .take    (take_skip),
    .level   (skip_cnt),
    .pending (skip_pend)
  );

  always_comb begin
    st_d = st_q;
    if (cyc_start) begin
      st_d = skip_pend ? SW_OFF : SW_BLANK;
    end else begin
      case (st_q)
        SW_BLANK: begin
          if (!pwm_on)         st_d = SW_OFF;
          else if (blank_done) st_d = ilim_trip ? SW_OFF : SW_CONDUCT;
        end
        SW_CONDUCT: if (!pwm_on) st_d = SW_OFF;
        default: st_d = SW_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SW_OFF;
      hiccup_req <= 1'b0;
    end else begin
      st_q       <= st_d;
      hiccup_req <= hic_d;
    end
  end

  assign gate_en = (st_q != SW_OFF) & pwm_on;
endmodule

// File: rtl/ocp_skip_ctrl_chk.sv
module ocp_skip_ctrl_chk #(
  parameter int SKIP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_start,
  input logic              pwm_on,
  input logic              gate_en,
  input logic              hiccup_req,
  input logic [SKIP_W-1:0] skip_cnt,
  input logic              skip_pend
);
  AST_START_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !skip_pend) |=> (gate_en == pwm_on)); // R2

  AST_SKIP_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && skip_pend) |=> !gate_en); // R6

  AST_HICCUP_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    hiccup_req |=> !hiccup_req); // R8

  AST_HICCUP_CLEARS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    hiccup_req |-> (skip_cnt == '0 && !skip_pend)); // R8

  AST_LEVEL_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_cnt != $past(skip_cnt) && skip_cnt != '0) |->
      (skip_cnt == $past(skip_cnt) + 1'b1 || skip_cnt == $past(skip_cnt) - 1'b1)); // R7
endmodule

bind ocp_skip_ctrl ocp_skip_ctrl_chk #(.SKIP_W(SKIP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_start  (cyc_start),
  .pwm_on     (pwm_on),
  .gate_en    (gate_en),
  .hiccup_req (hiccup_req),
  .skip_cnt   (skip_cnt),
  .skip_pend  (skip_pend)
);

// File: tb/ocp_skip_ctrl_tb.sv
module ocp_skip_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int B          = 4;
  localparam int SMAX       = 7;
  localparam int CYC_LEN    = 16;

  logic clk = 1'b0;
  logic rst_n, cyc_start, ilim_trip, pwm_on, ss_active, in_reg;
  logic gate_en, hiccup_req;

  int n_chk  = 0;
  int n_fail = 0;
  int m_cnt  = 0;
  int m_left = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocp_skip_ctrl #(.BLANK_CYC(B), .SKIP_MAX(SMAX)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .ilim_trip  (ilim_trip),
    .pwm_on     (pwm_on),
    .ss_active  (ss_active),
    .in_reg     (in_reg),
    .gate_en    (gate_en),
    .hiccup_req (hiccup_req)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // One switching period; counts gate-high and hiccup-high clocks.
  task automatic run_cycle(input int on_len, input bit trip_b, input bit trip_s,
                           output int g, output int h);
    g = 0;
    h = 0;
    cyc_start = 1'b1;
    pwm_on    = (on_len > 0);
    ilim_trip = trip_b;
    for (int k = 0; k < CYC_LEN; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 0) cyc_start = 1'b0;
      if (gate_en) g++;
      if (hiccup_req) h++;
      if (k + 1 == on_len) pwm_on = 1'b0;
      if (k == B) ilim_trip = trip_s;
      if (k == B + 1) ilim_trip = 1'b0;
    end
  endtask

  task automatic check_cycle(input string req, input int on_len, input bit trip_b, input bit trip_s);
    int g, h, eg, eh;
    bit smp;
    eh = 0;
    if (m_left > 0) begin
      eg = 0;
      m_left--;
    end else begin
      smp = (on_len >= B + 2);
      eg  = on_len;
      if (smp && trip_s) begin
        eg = B + 1;
        if (ss_active) begin
          if (m_cnt < SMAX) m_cnt++;
          m_left = m_cnt;
        end else if (in_reg) begin
          eh = 1;
          m_cnt = 0;
          m_left = 0;
        end
      end else if (smp && m_cnt > 0) begin
        m_cnt--;
      end
    end
    run_cycle(on_len, trip_b, trip_s, g, h);
    check(req, "gate clocks", g, eg);
    check(req, "hiccup clocks", h, eh);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cyc_start = 1'b1; pwm_on = 1'b1; ilim_trip = 1'b0;
    ss_active = 1'b1; in_reg = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "gate in reset", int'(gate_en), 0);
    check("R1", "hiccup in reset", int'(hiccup_req), 0);
    cyc_start = 1'b0; pwm_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_cycle("R1", 10, 1'b0, 1'b0);
  endtask

  task automatic t_normal();
    ss_active = 1'b0; in_reg = 1'b1;
    check_cycle("R2", 8, 1'b0, 1'b0);
    check_cycle("R2", 12, 1'b0, 1'b0);
    check_cycle("R2", 14, 1'b0, 1'b0);
  endtask

  task automatic t_blank();
    ss_active = 1'b0; in_reg = 1'b1;
    check_cycle("R3", 10, 1'b1, 1'b0);
    check_cycle("R3", 13, 1'b1, 1'b0);
  endtask

  task automatic t_ramp();
    ss_active = 1'b1; in_reg = 1'b0;
    for (int i = 0; i < 43; i++) check_cycle("R4 R5 R6", 10, 1'b0, 1'b1);
  endtask

  task automatic t_decay();
    ss_active = 1'b1; in_reg = 1'b0;
    while (m_left > 0) check_cycle("R6", 10, 1'b0, 1'b0);
    check_cycle("R7", 10, 1'b0, 1'b0);
    check_cycle("R7", 10, 1'b0, 1'b0);
    check_cycle("R7", 10, 1'b0, 1'b1);
    for (int i = 0; i < 14; i++) check_cycle("R7", 10, 1'b0, 1'b0);
  endtask

  task automatic t_early();
    ss_active = 1'b1; in_reg = 1'b0;
    check_cycle("R9", 3, 1'b1, 1'b1);
    check_cycle("R9", 5, 1'b1, 1'b1);
    check_cycle("R9", 10, 1'b0, 1'b0);
  endtask

  task automatic t_hiccup();
    ss_active = 1'b1; in_reg = 1'b0;
    check_cycle("R8", 10, 1'b0, 1'b1);
    check_cycle("R8", 10, 1'b0, 1'b0);
    ss_active = 1'b0; in_reg = 1'b1;
    check_cycle("R8", 10, 1'b0, 1'b1);
    ss_active = 1'b1; in_reg = 1'b0;
    check_cycle("R8", 10, 1'b0, 1'b1);
    check_cycle("R8", 10, 1'b0, 1'b0);
    check_cycle("R8", 10, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_blank();
    t_ramp();
    t_decay();
    t_early();
    t_hiccup();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule